// File: doc/BRIEF.md
# Resolver Angle and Speed Readout Sequencer

This block takes a single reading from a resolver-to-digital converter on behalf of a host. The host asks for one of three operations: an angle reading, a speed reading, or a fault-clear sequence. The block then drives the converter's active-low sample strobe and its two mode-select pins, and waits a minimum settling time. It then runs one 16-bit SPI transfer in mode 3 (clock idles high, data launched on the falling edge, captured on the rising edge, MSB first). It returns one formatted result together with a single-cycle valid strobe.

The formatting depends on the resolution and hysteresis settings that are captured when a read is accepted. A resolution code c selects a resolution of 10 + 2c bits. The block drives this code onto two resolution pins. An angle word is right-aligned by (16 − resolution) only when hysteresis is on. A speed word is always right-aligned and sign-extended from its new top bit. The minimum settling times are derived from parameters for the system clock period and the converter clock period. They are rounded up to whole system cycles.

Top module: `resolver_readout`

## Requirements
- R1: After reset, busy, rsp_valid and rsp_err are 0, snap_n, spi_cs_n and spi_sclk are 1, conv_mode is 2'b10 and res_code_o is 2'b01.
- R2: An angle request (req_kind 2'b00) drives conv_mode to 2'b00 and pulls snap_n low. spi_cs_n falls only after snap_n has been low for at least ceil((6·converter period + 20 ns) / system period) cycles, and snap_n stays low throughout the transfer.
- R3: A speed request (req_kind 2'b01) drives conv_mode to 2'b01 and otherwise follows the timing of R2.
- R4: Each transfer is 16 clocks in SPI mode 3. spi_sclk is high whenever spi_cs_n is high. MISO is captured MSB first on rising edges. MOSI carries 16'h0000 for angle and speed reads.
- R5: With hysteresis on, an angle result is the received word shifted right, unsigned, by 6 − 2c, where c is the resolution code.
- R6: With hysteresis off, an angle result is the received word unchanged, whatever the code.
- R7: A speed result is the received word shifted right by 6 − 2c with two's-complement sign extension, regardless of hysteresis.
- R8: rsp_valid is a one-cycle pulse in the cycle after spi_cs_n rises. For reads, snap_n is already high in that cycle, and busy stays high for at least ceil((2·converter period + 20 ns) / system period) cycles counted from that cycle.
- R9: A fault-clear request (req_kind 2'b10) sets conv_mode to 2'b10 and gives a low pulse on snap_n of at least the R8 hold length. It then sends 16'hFFFF on MOSI with snap_n high, and returns {8'h00, low byte of the received word}. Finally it gives a second low pulse of at least the same length, so two low pulses in total.
- R10: req_kind 2'b11 returns rsp_valid with rsp_err = 1 and rsp_data = 0 in the first cycle after the request edge, and spi_cs_n never falls.
- R11: A request made while busy is high is ignored: it produces no extra response, and it changes neither conv_mode nor res_code_o.
- R12: res_code_o shows the resolution code captured when a read request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 2 | 00 angle, 01 speed, 10 fault clear, 11 invalid |
| res_sel | input | 2 | Resolution code c (10 + 2c bits) |
| hyst_en | input | 1 | Hysteresis enable for angle formatting |
| busy | output | 1 | A sequence is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | Result is an invalid-request error |
| rsp_data | output | 16 | Formatted result |
| snap_n | output | 1 | Active-low sample strobe to the converter |
| conv_mode | output | 2 | Converter mode-select pins |
| res_code_o | output | 2 | Converter resolution pins |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |

## Verification
An invalid request is answered in the first cycle after its request edge. Every other result arrives exactly one cycle after spi_cs_n returns high. The bench records the cycle index of each of these events, counted from the request edge at falling-clock samples, and compares the indices directly. It does not wait for a fixed number of cycles. The settling and hold windows are minimums, so the bench measures the length of each low run of snap_n and the busy span after the response. It compares these counts against bounds computed from the clock periods.

// File: rtl/rdr_pkg.sv
// Shared types for the resolver readout sequencer.
// Assumes: request codes and converter mode codes share one 2-bit encoding.
package rdr_pkg;

    typedef enum logic [1:0] {
        K_POS   = 2'b00,
        K_VEL   = 2'b01,
        K_FAULT = 2'b10,
        K_BAD   = 2'b11
    } rdr_kind_e;

    localparam logic [1:0] MODE_CFG = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_F_PULSE1,
        S_F_GAP,
        S_XFER,
        S_F_PULSE2,
        S_RELEASE
    } rdr_state_e;

    // Whole system cycles covering a minimum time.
    function automatic int cyc_ceil(input int time_ns, input int period_ns);
        return (time_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/rdr_timer.sv
// Down-counter for the minimum settling windows.
// Assumes: load wins over counting; zero is high once the loaded count has run out.
module rdr_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2: a loaded window never expires in the following cycle unless it was 1 or less
    a_r2_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val > CW'(1)) |=> !zero);
endmodule

// File: rtl/rdr_spi_shift.sv
// Minimal SPI mode-3 shifter: one W-bit transfer per start pulse.
// Assumes: start arrives only while idle; HALF system cycles per clock half.
module rdr_spi_shift #(
    parameter int W    = 16,
    parameter int HALF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         cs_n,
    output logic         mosi,
    input  logic         miso
);
    localparam int HCW = $clog2(HALF) + 1;
    localparam int BCW = $clog2(W);

    typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH} sh_state_e;

    sh_state_e      st;
    logic [HCW-1:0] hc;
    logic [BCW-1:0] bits;
    logic [W-1:0]   txsr;

    // Walk the clock halves: launch on the falling edge, capture on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SH_IDLE; hc <= '0; bits <= '0; txsr <= '0;
            rx_word <= '0; sclk <= 1'b1; cs_n <= 1'b1; mosi <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: if (start) begin
                    cs_n <= 1'b0; txsr <= tx_word; bits <= '0;
                    hc <= HCW'(HALF - 1); st <= SH_LEAD;
                end
                SH_LEAD, SH_HIGH: begin
                    if (hc != '0) begin
                        hc <= hc - 1'b1;
                    end else if (st == SH_HIGH && bits == BCW'(W - 1)) begin
                        cs_n <= 1'b1; done <= 1'b1; st <= SH_IDLE;
                    end else begin
                        if (st == SH_HIGH) bits <= bits + 1'b1;
                        sclk <= 1'b0; mosi <= txsr[W-1]; txsr <= txsr << 1;
                        hc <= HCW'(HALF - 1); st <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (hc != '0) hc <= hc - 1'b1;
                    else begin
                        sclk <= 1'b1; rx_word <= {rx_word[W-2:0], miso};
                        hc <= HCW'(HALF - 1); st <= SH_HIGH;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // R4: the clock rests high outside a transfer
    a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // R4: MOSI moves only together with a falling clock
    a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/rdr_format.sv
// Aligns a received word according to the request kind and resolution code.
// Assumes: code c means 10 + 2c bits, so the alignment shift is 6 - 2c.
module rdr_format
    import rdr_pkg::*;
(
    input  rdr_kind_e   kind,
    input  logic [1:0]  res_code,
    input  logic        hyst,
    input  logic [15:0] raw,
    output logic [15:0] data
);
    logic [3:0] sh;

    assign sh = 4'd6 - {1'b0, res_code, 1'b0};

    // Choose unsigned, signed or byte formatting per kind.
    always_comb begin
        case (kind)
            K_POS:   data = hyst ? (raw >> sh) : raw;
            K_VEL:   data = 16'($signed(raw) >>> sh);
            K_FAULT: data = {8'h00, raw[7:0]};
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/resolver_readout.sv
// Sequencer for one converter reading: strobe, mode pins, settle, SPI read, format.
// Assumes: the converter clock period and system period are given in ns;
// minimum windows are rounded up to whole system cycles.
module resolver_readout
    import rdr_pkg::*;
#(
    parameter int SYS_CLK_NS  = 5,
    parameter int CONV_CLK_NS = 122,
    parameter int SCLK_HALF   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  res_sel,
    input  logic        hyst_en,
    output logic        busy,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [15:0] rsp_data,
    output logic        snap_n,
    output logic [1:0]  conv_mode,
    output logic [1:0]  res_code_o,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int SETUP_CYC = cyc_ceil(6 * CONV_CLK_NS + 20, SYS_CLK_NS);
    localparam int HOLD_CYC  = cyc_ceil(2 * CONV_CLK_NS + 20, SYS_CLK_NS);
    localparam int CW        = $clog2(SETUP_CYC + 1);

    rdr_state_e  st;
    rdr_kind_e   kind_q;
    rdr_kind_e   kind_in;
    logic        hyst_q;
    logic        spi_start, spi_done;
    logic [15:0] spi_rx, fmt_data;
    logic        tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;

    assign kind_in = rdr_kind_e'(req_kind);
    assign busy    = (st != S_IDLE);

    // Decide when a new minimum window starts and how long it is.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_IDLE: if (req_valid) begin
                if (kind_in == K_POS || kind_in == K_VEL) begin
                    tmr_load = 1'b1; tmr_val = CW'(SETUP_CYC);
                end else if (kind_in == K_FAULT) begin
                    tmr_load = 1'b1; tmr_val = CW'(HOLD_CYC);
                end
            end
            S_F_PULSE1, S_F_PULSE2: if (tmr_zero) begin
                tmr_load = 1'b1; tmr_val = CW'(HOLD_CYC);
            end
            S_XFER: if (spi_done) begin
                tmr_load = 1'b1; tmr_val = CW'(HOLD_CYC);
            end
            default: ;
        endcase
    end

    rdr_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    rdr_spi_shift #(.W(16), .HALF(SCLK_HALF)) u_spi (
        .clk(clk), .rst_n(rst_n), .start(spi_start),
        .tx_word((kind_q == K_FAULT) ? 16'hFFFF : 16'h0000),
        .done(spi_done), .rx_word(spi_rx),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );

    rdr_format u_fmt (
        .kind(kind_q), .res_code(res_code_o), .hyst(hyst_q), .raw(spi_rx), .data(fmt_data)
    );

    // Step through the strobe, settle, transfer and release phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; kind_q <= K_POS; hyst_q <= 1'b1; res_code_o <= 2'b01;
            snap_n <= 1'b1; conv_mode <= MODE_CFG; spi_start <= 1'b0;
            rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            spi_start <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    kind_q <= kind_in;
                    case (kind_in)
                        K_POS, K_VEL: begin
                            res_code_o <= res_sel; hyst_q <= hyst_en;
                            snap_n <= 1'b0; conv_mode <= req_kind; st <= S_SETUP;
                        end
                        K_FAULT: begin
                            snap_n <= 1'b0; conv_mode <= MODE_CFG; st <= S_F_PULSE1;
                        end
                        default: begin
                            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_data <= '0;
                        end
                    endcase
                end
                S_SETUP, S_F_GAP: if (tmr_zero) begin
                    spi_start <= 1'b1; st <= S_XFER;
                end
                S_F_PULSE1: if (tmr_zero) begin
                    snap_n <= 1'b1; st <= S_F_GAP;
                end
                S_XFER: if (spi_done) begin
                    rsp_valid <= 1'b1; rsp_data <= fmt_data;
                    if (kind_q == K_FAULT) begin
                        snap_n <= 1'b0; st <= S_F_PULSE2;
                    end else begin
                        snap_n <= 1'b1; st <= S_RELEASE;
                    end
                end
                S_F_PULSE2: if (tmr_zero) begin
                    snap_n <= 1'b1; st <= S_RELEASE;
                end
                S_RELEASE: if (tmr_zero) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R8: a data response is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |=> !rsp_valid);
    // R10: the error flag only travels with a response
    a_r10_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    // R2: the sample strobe is held low across a read transfer
    a_r2_snap_low_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && kind_q != K_FAULT) |-> !snap_n);
    // R9: the fault register is read in configuration mode with the strobe high
    a_r9_cfg_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && kind_q == K_FAULT) |-> (conv_mode == MODE_CFG && snap_n));
    // R11: configuration pins hold while a sequence runs
    a_r11_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(res_code_o) && $stable(conv_mode)));
endmodule

// File: tb/test_resolver_readout.sv
module test_resolver_readout;
    localparam int SYS_NS    = 5;
    localparam int CONV_NS   = 122;
    localparam int SETUP_MIN = (6 * CONV_NS + 20 + SYS_NS - 1) / SYS_NS;
    localparam int HOLD_MIN  = (2 * CONV_NS + 20 + SYS_NS - 1) / SYS_NS;
    localparam int NV        = 11;

    // {kind[37:36], code[35:34], hyst[33], raw[32:17], expected[16:1], err[0]}
    localparam logic [37:0] VECS [NV] = '{
        {2'd0, 2'd1, 1'b1, 16'hABCD, 16'h0ABC, 1'b0},
        {2'd0, 2'd0, 1'b0, 16'hABCD, 16'hABCD, 1'b0},
        {2'd0, 2'd0, 1'b1, 16'hFFC0, 16'h03FF, 1'b0},
        {2'd0, 2'd3, 1'b1, 16'h1234, 16'h1234, 1'b0},
        {2'd1, 2'd1, 1'b1, 16'h8000, 16'hF800, 1'b0},
        {2'd1, 2'd0, 1'b0, 16'h7FC0, 16'h01FF, 1'b0},
        {2'd1, 2'd2, 1'b0, 16'hFFFC, 16'hFFFF, 1'b0},
        {2'd1, 2'd3, 1'b1, 16'h8001, 16'h8001, 1'b0},
        {2'd1, 2'd2, 1'b1, 16'h4004, 16'h1001, 1'b0},
        {2'd2, 2'd1, 1'b1, 16'h12A5, 16'h00A5, 1'b0},
        {2'd3, 2'd1, 1'b1, 16'h5555, 16'h0000, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, hyst_en = 1'b0;
    logic [1:0] req_kind = 2'b00, res_sel = 2'b00;
    logic busy, rsp_valid, rsp_err, snap_n, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic [15:0] rsp_data;
    logic [1:0] conv_mode, res_code_o;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    resolver_readout i_resolver_readout (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .res_sel(res_sel), .hyst_en(hyst_en), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .snap_n(snap_n), .conv_mode(conv_mode),
        .res_code_o(res_code_o), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Converter model: presents the word MSB first, captures MOSI on rising SCLK.
    logic [15:0] slave_word = 16'h0000;
    logic [15:0] mosi_cap = 16'h0000;
    logic [3:0]  sbit = 4'd15;
    assign spi_miso = slave_word[sbit];
    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) sbit <= 4'd15;
        else begin
            sbit     <= sbit - 4'd1;
            mosi_cap <= {mosi_cap[14:0], spi_mosi};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        total++;
        if (act < lim) begin
            bad++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    // One operation; interfere pulses a second request while busy (R11).
    task automatic run_op(input logic [37:0] v, input bit interfere);
        logic [1:0] kind, code;
        logic [15:0] expv;
        int cyc = 0, run = 0, nruns = 0, minrun = 1 << 30, lowrun_at_cs = 0;
        int cs_falls = 0, cs_rise_cyc = -1, rsp_cyc = -1, rsp_cnt = 0, busy_after = 0;
        logic prev_cs = 1'b1, prev_snap = 1'b1, sclk_bad = 1'b0, snap_at_rsp = 1'b0;
        logic [1:0] mode_at_cs = 2'b11;
        logic [15:0] got_data = 16'h0;
        logic got_err = 1'b0;
        kind = v[37:36]; code = v[35:34]; expv = v[16:1];
        slave_word = v[32:17];
        req_kind = kind; res_sel = code; hyst_en = v[33]; req_valid = 1'b1;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) req_valid = 1'b0;
            if (interfere && cyc == 10) begin
                req_valid = 1'b1; req_kind = 2'b01; res_sel = 2'b11;
            end
            if (interfere && cyc == 11) req_valid = 1'b0;
            if (spi_cs_n && !spi_sclk) sclk_bad = 1'b1;
            if (!snap_n) run++;
            if (snap_n && !prev_snap) begin
                nruns++;
                if (run < minrun) minrun = run;
                run = 0;
            end
            if (!spi_cs_n && prev_cs) begin
                cs_falls++; mode_at_cs = conv_mode; lowrun_at_cs = run;
            end
            if (spi_cs_n && !prev_cs) cs_rise_cyc = cyc;
            if (rsp_valid) begin
                rsp_cnt++;
                if (rsp_cyc < 0) begin
                    rsp_cyc = cyc; got_data = rsp_data; got_err = rsp_err; snap_at_rsp = snap_n;
                end
            end
            if (rsp_cyc > 0 && busy) busy_after++;
            prev_cs = spi_cs_n; prev_snap = snap_n;
            if (rsp_cyc > 0 && !busy && snap_n) break;
        end
        if (cyc >= 3000) chk("R8 op completes", 0, 1);
        chk("R4 sclk idles high", sclk_bad, 0);
        chk("R11 one response only", rsp_cnt, 1);
        if (kind == 2'b11) begin
            chk("R10 error flag", got_err, 1);
            chk("R10 error data", got_data, 0);
            chk("R10 response cycle", rsp_cyc, 1);
            chk("R10 no transfer", cs_falls, 0);
        end else begin
            chk("R8 no error", got_err, 0);
            chk("R8 response after cs rise", rsp_cyc, cs_rise_cyc + 1);
            chk("R4 one transfer", cs_falls, 1);
            if (kind == 2'b10) begin
                chk("R9 fault data", got_data, expv);
                chk("R9 config mode", mode_at_cs, 2'b10);
                chk("R9 mosi address", mosi_cap, 16'hFFFF);
                chk("R9 strobe high in transfer", lowrun_at_cs, 0);
                chk("R9 two pulses", nruns, 2);
                chk_ge("R9 pulse width", minrun, HOLD_MIN);
            end else begin
                if (kind == 2'b00) begin
                    if (v[33]) chk("R5 angle aligned", got_data, expv);
                    else       chk("R6 angle raw", got_data, expv);
                    chk("R2 angle mode", mode_at_cs, 2'b00);
                end else begin
                    chk("R7 speed signed", got_data, expv);
                    chk("R3 speed mode", mode_at_cs, 2'b01);
                end
                chk_ge("R2 settle before transfer", lowrun_at_cs, SETUP_MIN);
                chk("R4 mosi idle word", mosi_cap, 16'h0000);
                chk("R8 strobe high at response", snap_at_rsp, 1);
                chk_ge("R8 busy hold", busy_after, HOLD_MIN);
                chk("R12 resolution pins", res_code_o, code);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R8 watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_err", rsp_err, 0);
        chk("R1 snap_n", snap_n, 1);
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sclk", spi_sclk, 1);
        chk("R1 mode", conv_mode, 2'b10);
        chk("R1 res pins", res_code_o, 2'b01);
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], 1'b0);
            repeat (2) @(negedge clk);
        end
        // R11: a speed request at cycle 10 of an angle read is dropped
        run_op(VECS[0], 1'b1);
        repeat (5) @(negedge clk);
        chk("R11 no late response", rsp_valid, 0);
        chk("R11 idle after", busy, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule